// File: doc/BRIEF.md
# Dual Programmable Time-Base Interrupt Generator

This block raises two periodic interrupt requests from a single shared 15-bit up-counter. The counter advances on ticks from one of two sources. The first source is a system clock-enable pulse divided by four. The second is a dedicated time-base clock-enable pulse. Both sources arrive as single-cycle enables on one fabric clock.

Each of the two time bases picks its own power-of-two period with a short select field. When that period expires, the time base sets a sticky request flag. Software clears each flag with a write-one-to-clear strobe. All configuration sits in one 8-bit control register, which is written and read back over a simple register port.

Bit positions of the control register: bit 7 is the common enable, bit 6 is the clock select, bits 5:4 are the period select of time base 1, bit 3 is the low-power mode bit, and bits 2:0 are the period select of time base 0.

Top module: `tbase_irq`

## Requirements
- R1: After reset the control register reads 0x37 and both request outputs are low.
- R2: A write stores all eight bits, including the low-power bit 3, and `reg_rdata` returns the stored byte from the cycle after the write.
- R3: With bit 7 set, request 0 (`tb_irq[0]`) sets after exactly 2^(8+c) counting ticks from the enabling write, where c is bits 2:0 (0 to 7).
- R4: With bit 7 set, request 1 (`tb_irq[1]`) sets after exactly 4096·2^c counting ticks from the enabling write, where c is bits 5:4 (0 to 3).
- R5: With bit 6 at 1 the counter advances on each `tb_ce` pulse and ignores `sys_ce`. With bit 6 at 0 it advances once per four `sys_ce` pulses and ignores `tb_ce`.
- R6: While bit 7 is 0 the counter is held at zero and prescaled to zero, and no request sets. A request that is already set stays set.
- R7: A request stays set until a 1 is strobed on its bit of `flag_clr`, after which it reads low on the next cycle. A clear that coincides with a new timeout leaves the request set.
- R8: Changing a period select while enabled does not restart the shared counter. The new period applies from the next tick, measured against the running count.
- R9: The low-power bit 3 has no effect on any period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read-back |
| sys_ce | input | 1 | System clock-enable pulse (divided by four when selected) |
| tb_ce | input | 1 | Dedicated time-base clock-enable pulse |
| flag_clr | input | 2 | Write-one-to-clear strobes, bit i clears request i |
| tb_irq | output | 2 | Sticky interrupt requests of time base 0 and 1 |

## Verification
The bound checker watches, on every cycle, the flag rules and the effect of the enable. A set flag stays set until it is cleared. A clear without a coincident timeout drops the flag. A timeout always leaves the flag set. A flag rises only after a tick. The counter sits at zero while disabled, holds between ticks, and no flag sets while disabled.

The exact period of every select code can only be shown by the bench's timed sweeps, as can the divide-by-four of the system source and the counting across a live period change. The bench's scenarios also show read-back, the inertness of the low-power bit, and a clear that lands in the same cycle as a timeout.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int CNT_W     = 15;
    localparam int TB0_BASE  = 8;
    localparam int TB0_SEL_W = 3;
    localparam int TB1_BASE  = 12;
    localparam int TB1_SEL_W = 2;
    localparam int NUM_TB    = 2;
    localparam int PRE_W     = 2;
    localparam int SEL_MAX_W = (TB0_SEL_W > TB1_SEL_W) ? TB0_SEL_W : TB1_SEL_W;

    typedef struct packed {
        logic                 run;
        logic                 src_tb;
        logic [TB1_SEL_W-1:0] per1;
        logic                 lowpwr;
        logic [TB0_SEL_W-1:0] per0;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = ctrl_t'(8'h37);

endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
    import tbase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output ctrl_t      ctrl_q,
    output logic [7:0] rdata
);

    typedef struct packed {
        ctrl_t ctrl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.ctrl = ctrl_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q = st_q.ctrl;
    assign rdata  = st_q.ctrl;

endmodule

// File: rtl/tbase_ticksrc.sv
module tbase_ticksrc
    import tbase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic src_tb,
    input  logic sys_ce,
    input  logic tb_ce,
    output logic tick
);

    typedef struct packed {
        logic [PRE_W-1:0] div;
    } st_t;

    st_t  st_d, st_q;
    logic sys_tick;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.div = '0;
        end else if (sys_ce) begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Select is a registered control bit, so a source change lands only on a fabric edge.
    always_comb begin
        sys_tick = run && sys_ce && (st_q.div == {PRE_W{1'b1}});
        tick     = src_tb ? (run && tb_ce) : sys_tick;
    end

endmodule

// File: rtl/tbase_cnt.sv
module tbase_cnt
    import tbase_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  tick,
    input  logic [TB0_SEL_W-1:0]  per0,
    input  logic [TB1_SEL_W-1:0]  per1,
    output logic [CNT_W-1:0]      cnt,
    output logic [NUM_TB-1:0]     tmo
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    logic [SEL_MAX_W-1:0] sel  [NUM_TB];
    int                   base [NUM_TB];

    assign sel[0]  = SEL_MAX_W'(per0);
    assign sel[1]  = SEL_MAX_W'(per1);
    assign base[0] = TB0_BASE;
    assign base[1] = TB1_BASE;

    function automatic logic low_all_ones(input logic [CNT_W-1:0] v, input int n);
        logic r;
        r = 1'b1;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < n && !v[i]) begin
                r = 1'b0;
            end
        end
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A timeout fires on the tick that rolls the bits below the selected power to zero.
    for (genvar g = 0; g < NUM_TB; g++) begin : g_tap
        always_comb begin
            tmo[g] = run && tick && low_all_ones(st_q.cnt, base[g] + int'(sel[g]));
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/tbase_flags.sv
module tbase_flags
    import tbase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_TB-1:0] set,
    input  logic [NUM_TB-1:0] clr,
    output logic [NUM_TB-1:0] flag
);

    typedef struct packed {
        logic [NUM_TB-1:0] flag;
    } st_t;

    st_t st_d, st_q;

    for (genvar g = 0; g < NUM_TB; g++) begin : g_flag
        always_comb begin
            // A set in the same cycle as a clear wins.
            st_d.flag[g] = (st_q.flag[g] && !clr[g]) || set[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/tbase_irq.sv
module tbase_irq
    import tbase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sys_ce,
    input  logic       tb_ce,
    input  logic [1:0] flag_clr,
    output logic [1:0] tb_irq
);

    ctrl_t              ctl_q;
    logic               tick;
    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_TB-1:0]  tmo;

    tbase_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .ctrl_q (ctl_q),
        .rdata  (reg_rdata)
    );

    tbase_ticksrc u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctl_q.run),
        .src_tb (ctl_q.src_tb),
        .sys_ce (sys_ce),
        .tb_ce  (tb_ce),
        .tick   (tick)
    );

    tbase_cnt u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_q.run),
        .tick  (tick),
        .per0  (ctl_q.per0),
        .per1  (ctl_q.per1),
        .cnt   (cnt_q),
        .tmo   (tmo)
    );

    tbase_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (tmo),
        .clr   (flag_clr),
        .flag  (tb_irq)
    );

endmodule

// File: rtl/tbase_irq_chk.sv
module tbase_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        tick,
    input logic [14:0] cnt,
    input logic [1:0]  tmo,
    input logic [1:0]  clr,
    input logic [1:0]  irq
);

    p_sticky0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] && !clr[0] |=> irq[0]);
    p_sticky1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] && !clr[1] |=> irq[1]);

    p_clear0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr[0] && !tmo[0] |=> !irq[0]);
    p_clear1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr[1] && !tmo[1] |=> !irq[1]);

    p_set_wins0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo[0] |=> irq[0]);
    p_set_wins1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo[1] |=> irq[1]);

    p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

    p_no_set_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run && irq == 2'b00 |=> irq == 2'b00);

    p_rise_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) || $rose(irq[1]) |-> $past(tick));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick |=> $stable(cnt));

endmodule

bind tbase_irq tbase_irq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctl_q.run),
    .tick  (tick),
    .cnt   (cnt_q),
    .tmo   (tmo),
    .clr   (flag_clr),
    .irq   (tb_irq)
);

// File: tb/tbase_irq_test.sv
module tbase_irq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sys_lvl = 1'b0;
    logic       sys_half_mode = 1'b0;
    logic       half = 1'b0;
    logic       sys_ce;
    logic       tb_ce = 1'b0;
    logic [1:0] flag_clr = 2'b00;
    logic [1:0] tb_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    always @(posedge clk) half <= #1 ~half;
    assign sys_ce = sys_half_mode ? half : sys_lvl;

    tbase_irq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sys_ce    (sys_ce),
        .tb_ce     (tb_ce),
        .flag_clr  (flag_clr),
        .tb_irq    (tb_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic clr_all();
        @(negedge clk);
        flag_clr = 2'b11;
        @(posedge clk);
        #1;
        flag_clr = 2'b00;
    endtask

    task automatic measure(input int idx, input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(posedge clk);
            #1;
            n++;
            if (tb_irq[idx]) break;
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Disable with the given layout, clear flags, then enable it.
    task automatic restart(input logic [7:0] cfg);
        wr(cfg & 8'h7f);
        clr_all();
        wr(cfg | 8'h80);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 rdata", int'(reg_rdata), 8'h37);
        check("R1 irq0", int'(tb_irq[0]), 0);
        check("R1 irq1", int'(tb_irq[1]), 0);
        rst_n = 1'b1;
        idle(2);
        check("R1 rdata after release", int'(reg_rdata), 8'h37);

        // R2 readback including the low-power bit
        wr(8'h08);
        check("R2 readback 08", int'(reg_rdata), 8'h08);
        wr(8'h5a);
        check("R2 readback 5a", int'(reg_rdata), 8'h5a);

        // R3 time base 0 sweep, dedicated clock every cycle (R9 with bit 3 on odd codes)
        tb_ce = 1'b1;
        for (int c = 0; c < 8; c++) begin
            logic [7:0] cfg;
            cfg = 8'h40 | 8'h30 | 8'(c) | ((c % 2 == 1) ? 8'h08 : 8'h00);
            restart(cfg);
            measure(0, (1 << (8 + c)) + 4, n);
            check((c % 2 == 1) ? "R3/R9 tb0 period" : "R3 tb0 period", n, 1 << (8 + c));
        end
        check("R2 readback sweep", int'(reg_rdata), 8'hff);

        // R4 time base 1 sweep
        for (int c = 0; c < 4; c++) begin
            restart(8'h40 | 8'(c << 4) | 8'h07);
            measure(1, (4096 << c) + 4, n);
            check("R4 tb1 period", n, 4096 << c);
        end

        // R5 dedicated source selected: sys_ce ignored
        tb_ce = 1'b0;
        sys_lvl = 1'b1;
        restart(8'h40);
        idle(600);
        check("R5 sys ignored when tb selected", int'(tb_irq[0]), 0);

        // R5 system source divided by four, tb_ce ignored
        tb_ce = 1'b1;
        restart(8'h00);
        tb_ce = 1'b0;
        measure(0, 1100, n);
        check("R5 sys/4 period", n, 1024);

        // R5 system source at half rate: 8 fabric cycles per tick, phase of at most one cycle
        sys_half_mode = 1'b1;
        restart(8'h00);
        measure(0, 2100, n);
        check("R5 sys half-rate period", (n == 2047 || n == 2048) ? 1 : 0, 1);
        sys_half_mode = 1'b0;
        sys_lvl = 1'b0;

        // R7 clear coinciding with a timeout keeps the flag
        tb_ce = 1'b1;
        restart(8'h40);
        measure(0, 300, n);
        check("R7 first timeout", n, 256);
        idle(255);
        flag_clr = 2'b01;
        @(posedge clk);
        #1;
        flag_clr = 2'b00;
        check("R7 clear with timeout keeps set", int'(tb_irq[0]), 1);
        idle(5);
        check("R7 sticky", int'(tb_irq[0]), 1);

        // R6 disable keeps pending flag, blocks new ones
        wr(8'h40);
        idle(300);
        check("R6 pending kept while disabled", int'(tb_irq[0]), 1);
        flag_clr = 2'b01;
        @(posedge clk);
        #1;
        flag_clr = 2'b00;
        check("R7 plain clear", int'(tb_irq[0]), 0);
        idle(600);
        check("R6 no set while disabled", int'(tb_irq[0]), 0);

        // R8 live period change keeps the counter running
        restart(8'h40);
        idle(100);
        wr(8'hc1);
        for (int t = 102; t <= 512; t++) begin
            @(posedge clk);
            #1;
            if (t == 256) check("R8 no timeout at old period", int'(tb_irq[0]), 0);
            if (t == 511) check("R8 not before new period", int'(tb_irq[0]), 0);
            if (t == 512) check("R8 timeout at new period", int'(tb_irq[0]), 1);
        end

        finish_run();
    end

endmodule